// File: doc/BRIEF.md
# PTP Event Timestamp Capture for an MII Port

This block sits beside one MII port. It watches the transmit and receive nibble streams. When a Layer-2 precision-time event message goes past, it records a 64-bit local time value. One role input chooses master or slave operation. In master operation the block stamps outgoing Sync messages and incoming Delay_Req messages. In slave operation it stamps outgoing Delay_Req messages and incoming Sync messages. No other message type is ever stamped.

The time is sampled on the clock edge that sees the last nibble of the start-of-frame delimiter. That value is held as pending and becomes visible only when the frame ends cleanly. A frame ends cleanly when it was long enough, carried the right EtherType and message type, and had no receive error. Each direction has its own event flag. While a flag is set, the snapshot for that direction is frozen until software pulses the matching acknowledge. A mode input turns the freeze off, so that every qualifying frame overwrites the snapshot.

For received frames, the block also commits the 48-bit sender identity and the 16-bit sequence number, together with the timestamp.

Top module: `ptp_mii_stamp`

## Requirements
- R1: After reset, both snapshots, both event flags, the sender identity and the sequence number are all zero.
- R2: A frame starts with preamble nibbles of value 5, followed by the nibble D. The time input is sampled on the clock edge that sees the D nibble, and that sampled value is what gets committed.
- R3: Body bytes are counted from 0, starting just after the delimiter. Each byte arrives low nibble first. A frame qualifies only if bytes 12 and 13 are 0x88 and 0xF7, and the low nibble of byte 14 is the wanted message type (0 = Sync, 1 = Delay_Req). Types 8 (Follow_Up), 9 (Delay_Resp) and any other EtherType never commit.
- R4: With the role input at 0 (master), transmit wants Sync and receive wants Delay_Req. With the role input at 1 (slave), transmit wants Delay_Req and receive wants Sync.
- R5: A commit happens on the first clock edge at which the data-valid signal of that direction is sampled low after a frame. A frame with fewer than 46 body bytes (including CRC) never commits.
- R6: A commit sets that direction's event flag. While the flag is set and the no-lock input is 0, later qualifying frames leave the snapshot unchanged. A one-cycle acknowledge pulse clears the flag.
- R7: With the no-lock input at 1, every qualifying frame overwrites the snapshot, whatever the flag holds, and sets the flag.
- R8: On each receive commit, body bytes 34 to 39 are stored as the sender identity, and bytes 44 and 45 as the sequence number. In both fields the earliest byte is the most significant. Both outputs hold their values between commits.
- R9: A receive frame in which the receive-error input is high on any nibble never commits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the MII streams and the time input |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_slave | input | 1 | Role: 0 = master, 1 = slave |
| cfg_nolock | input | 1 | 1 = snapshots are never frozen |
| now_time | input | 64 | Local time value to be sampled |
| mii_tx_en | input | 1 | Transmit data valid |
| mii_txd | input | 4 | Transmit nibble |
| mii_rx_dv | input | 1 | Receive data valid |
| mii_rx_er | input | 1 | Receive error flag |
| mii_rxd | input | 4 | Receive nibble |
| ack_tx | input | 1 | Write-one pulse that clears the transmit event flag |
| ack_rx | input | 1 | Write-one pulse that clears the receive event flag |
| tx_snap | output | 64 | Committed transmit timestamp |
| rx_snap | output | 64 | Committed receive timestamp |
| tx_evt | output | 1 | Transmit event flag |
| rx_evt | output | 1 | Receive event flag |
| rx_src_id | output | 48 | Sender identity from the last receive commit |
| rx_seq_id | output | 16 | Sequence number from the last receive commit |

## Verification
The bench targets the following corner cases:
- **Timestamp edge.** Sampling one cycle early or late, at the first delimiter nibble or at the end of the frame, would give a timestamp that differs by a multiple of the time step.
- **Role and type tables.** Frames are sent in both directions, under both roles, with all four event and general message types. A swapped table would stamp Follow_Up or the wrong direction.
- **Lock and release.** Back-to-back qualifying frames are sent with and without acknowledge, and with the no-lock input set. A design that ignored the flag would overwrite a frozen value; one that ignored the no-lock input would keep a stale value.
- **Frames that must not commit.** Frames that end early, carry a foreign EtherType, or have a receive error on one nibble all check that the frame is dropped, and that the identity and sequence fields stay put.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;

  typedef enum logic [1:0] {PS_IDLE, PS_PRE, PS_BODY, PS_DROP} pstate_e;

  localparam logic [3:0] PRE_NIB   = 4'h5;
  localparam logic [3:0] SFD_HI    = 4'hD;
  localparam logic [3:0] MSG_SYNC  = 4'h0;
  localparam logic [3:0] MSG_DREQ  = 4'h1;
  localparam int         ETYPE_BYTE = 12;
  localparam int         TYPE_BYTE  = 14;
  localparam int         SRC_BYTE   = 34;
  localparam int         SEQ_BYTE   = 44;

  // body nibble positions that take part in the type comparison
  function automatic logic is_check_nib(input int idx);
    return (idx >= 2*ETYPE_BYTE) && (idx <= 2*TYPE_BYTE);
  endfunction

  // expected nibble at a compared position, low nibble of each byte first
  function automatic logic [3:0] expect_nib(input logic [15:0] et,
                                            input logic [3:0] mt,
                                            input int idx);
    case (idx - 2*ETYPE_BYTE)
      0:       return et[11:8];
      1:       return et[15:12];
      2:       return et[3:0];
      3:       return et[7:4];
      default: return mt;
    endcase
  endfunction

  // whether a body nibble lies inside a big-endian field
  function automatic logic in_field(input int idx, input int first_byte,
                                    input int width);
    return (idx >= 2*first_byte) && (idx < 2*first_byte + width/4);
  endfunction

  // bit offset of a body nibble inside a big-endian field
  function automatic int field_lsb(input int idx, input int first_byte,
                                   input int width);
    int k;
    k = (idx - 2*first_byte) / 2;
    return width - 8 - 8*k + ((idx % 2) * 4);
  endfunction

endpackage

// File: rtl/ptp_nib_parser.sv
module ptp_nib_parser
  import ptp_stamp_pkg::*;
#(
  parameter int          MIN_BYTES = 46,
  parameter logic [15:0] ETYPE     = 16'h88F7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid,
  input  logic       er,
  input  logic [3:0] nib,
  input  logic [3:0] want_type,
  output logic       sfd_hit,
  output logic       frame_ok
);
  localparam int MIN_NIB = 2*MIN_BYTES;
  localparam int CW      = $clog2(MIN_NIB + 1);

  pstate_e       st;
  logic [CW-1:0] ncnt;
  logic          mism;
  logic          err_seen;
  logic          chk_pos;
  logic [3:0]    exp_n;

  always_comb begin
    chk_pos  = is_check_nib(int'(ncnt));
    exp_n    = expect_nib(ETYPE, want_type, int'(ncnt));
    sfd_hit  = valid && (st == PS_PRE) && (nib == SFD_HI);
    frame_ok = !valid && (st == PS_BODY) && !mism && !err_seen &&
               (ncnt == CW'(MIN_NIB));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !valid) begin
      st       <= PS_IDLE;
      ncnt     <= '0;
      mism     <= 1'b0;
      err_seen <= 1'b0;
    end else begin
      err_seen <= err_seen | er;
      case (st)
        PS_IDLE: st <= (nib == PRE_NIB) ? PS_PRE : PS_DROP;
        PS_PRE: begin
          if (nib == SFD_HI) begin
            st   <= PS_BODY;
            ncnt <= '0;
          end else if (nib != PRE_NIB) begin
            st <= PS_DROP;
          end
        end
        PS_BODY: begin
          if (ncnt != CW'(MIN_NIB)) ncnt <= ncnt + CW'(1);
          if (chk_pos && (nib != exp_n)) mism <= 1'b1;
        end
        default: st <= PS_DROP;
      endcase
    end
  end

  // R2: one delimiter hit per frame
  a_r2_single_sfd: assert property (@(posedge clk) disable iff (!rst_n)
    sfd_hit |=> !sfd_hit);
  // R5: a good end is seen only on the fall of data-valid
  a_r5_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> (!valid && $past(valid)));
  // R9: an error nibble prevents the frame from ending well
  a_r9_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && er) |=> !frame_ok);

endmodule

// File: rtl/ptp_snap_slot.sv
module ptp_snap_slot #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sfd_hit,
  input  logic          frame_ok,
  input  logic [TW-1:0] now,
  input  logic          nolock,
  input  logic          ack,
  output logic [TW-1:0] snap,
  output logic          evt,
  output logic          commit
);
  logic [TW-1:0] pend;

  assign commit = frame_ok && (!evt || nolock);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      snap <= '0;
      evt  <= 1'b0;
    end else begin
      if (sfd_hit) pend <= now;
      if (commit) snap <= pend;
      if (commit)   evt <= 1'b1;
      else if (ack) evt <= 1'b0;
    end
  end

  // R6: a frozen snapshot does not move
  a_r6_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !nolock) |=> $stable(snap));
  // R6: a good frame on a free slot raises the flag
  a_r6_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && !evt) |=> evt);
  // R7: without locking every good frame lands
  a_r7_nolock_land: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && nolock) |=> (evt && (snap == $past(pend))));

endmodule

// File: rtl/ptp_meta_grab.sv
module ptp_meta_grab
  import ptp_stamp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid,
  input  logic [3:0]  nib,
  input  logic        sfd_hit,
  input  logic        commit,
  output logic [47:0] src_id,
  output logic [15:0] seq_id
);
  localparam int LAST = 2*(SEQ_BYTE + 2);
  localparam int IW   = $clog2(LAST + 1);

  logic          act;
  logic [IW-1:0] idx;
  logic [47:0]   src_w;
  logic [15:0]   seq_w;
  int            i;

  assign i = int'(idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act   <= 1'b0;
      idx   <= '0;
      src_w <= '0;
      seq_w <= '0;
    end else if (!valid) begin
      act <= 1'b0;
    end else if (sfd_hit) begin
      act <= 1'b1;
      idx <= '0;
    end else if (act) begin
      if (in_field(i, SRC_BYTE, 48)) src_w[field_lsb(i, SRC_BYTE, 48) +: 4] <= nib;
      if (in_field(i, SEQ_BYTE, 16)) seq_w[field_lsb(i, SEQ_BYTE, 16) +: 4] <= nib;
      if (idx != IW'(LAST)) idx <= idx + IW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_id <= '0;
      seq_id <= '0;
    end else if (commit) begin
      src_id <= src_w;
      seq_id <= seq_w;
    end
  end

  // R8: identity and sequence move only with a receive commit
  a_r8_meta_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(src_id) && $stable(seq_id)));

endmodule

// File: rtl/ptp_mii_stamp.sv
module ptp_mii_stamp
  import ptp_stamp_pkg::*;
#(
  parameter int          TW        = 64,
  parameter int          MIN_BYTES = 46,
  parameter logic [15:0] ETYPE     = 16'h88F7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_slave,
  input  logic          cfg_nolock,
  input  logic [TW-1:0] now_time,
  input  logic          mii_tx_en,
  input  logic [3:0]    mii_txd,
  input  logic          mii_rx_dv,
  input  logic          mii_rx_er,
  input  logic [3:0]    mii_rxd,
  input  logic          ack_tx,
  input  logic          ack_rx,
  output logic [TW-1:0] tx_snap,
  output logic [TW-1:0] rx_snap,
  output logic          tx_evt,
  output logic          rx_evt,
  output logic [47:0]   rx_src_id,
  output logic [15:0]   rx_seq_id
);
  logic [3:0] tx_want, rx_want;
  logic       tx_sfd, rx_sfd, tx_ok, rx_ok, tx_commit, rx_commit;

  assign tx_want = cfg_slave ? MSG_DREQ : MSG_SYNC;
  assign rx_want = cfg_slave ? MSG_SYNC : MSG_DREQ;

  ptp_nib_parser #(.MIN_BYTES(MIN_BYTES), .ETYPE(ETYPE)) u_tx_parse (
    .clk(clk), .rst_n(rst_n), .valid(mii_tx_en), .er(1'b0), .nib(mii_txd),
    .want_type(tx_want), .sfd_hit(tx_sfd), .frame_ok(tx_ok));

  ptp_nib_parser #(.MIN_BYTES(MIN_BYTES), .ETYPE(ETYPE)) u_rx_parse (
    .clk(clk), .rst_n(rst_n), .valid(mii_rx_dv), .er(mii_rx_er), .nib(mii_rxd),
    .want_type(rx_want), .sfd_hit(rx_sfd), .frame_ok(rx_ok));

  ptp_snap_slot #(.TW(TW)) u_tx_slot (
    .clk(clk), .rst_n(rst_n), .sfd_hit(tx_sfd), .frame_ok(tx_ok),
    .now(now_time), .nolock(cfg_nolock), .ack(ack_tx),
    .snap(tx_snap), .evt(tx_evt), .commit(tx_commit));

  ptp_snap_slot #(.TW(TW)) u_rx_slot (
    .clk(clk), .rst_n(rst_n), .sfd_hit(rx_sfd), .frame_ok(rx_ok),
    .now(now_time), .nolock(cfg_nolock), .ack(ack_rx),
    .snap(rx_snap), .evt(rx_evt), .commit(rx_commit));

  ptp_meta_grab u_rx_meta (
    .clk(clk), .rst_n(rst_n), .valid(mii_rx_dv), .nib(mii_rxd),
    .sfd_hit(rx_sfd), .commit(rx_commit),
    .src_id(rx_src_id), .seq_id(rx_seq_id));

  // R4: the two directions never wait for the same message type
  a_r4_roles_differ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_want != rx_want);
  // R6: a transmit snapshot change implies a commit on the previous edge
  a_r6_tx_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_commit |=> $stable(tx_snap));

endmodule

// File: tb/ptp_mii_stamp_test.sv
module ptp_mii_stamp_test;
  localparam int          CLK_P  = 10;
  localparam logic [15:0] PTP_ET = 16'h88F7;
  localparam int          MINB   = 46;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_slave = 1'b0, cfg_nolock = 1'b0;
  logic [63:0] now_time = 64'h0123_4567_89AB_0000;
  logic        mii_tx_en = 1'b0, mii_rx_dv = 1'b0, mii_rx_er = 1'b0;
  logic [3:0]  mii_txd = 4'h0, mii_rxd = 4'h0;
  logic        ack_tx = 1'b0, ack_rx = 1'b0;
  logic [63:0] tx_snap, rx_snap;
  logic        tx_evt, rx_evt;
  logic [47:0] rx_src_id;
  logic [15:0] rx_seq_id;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [63:0] m_snap [2];
  logic        m_evt  [2];
  logic [47:0] m_src;
  logic [15:0] m_seq;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) now_time <= now_time + 64'd7;

  ptp_mii_stamp uut (
    .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .cfg_nolock(cfg_nolock),
    .now_time(now_time), .mii_tx_en(mii_tx_en), .mii_txd(mii_txd),
    .mii_rx_dv(mii_rx_dv), .mii_rx_er(mii_rx_er), .mii_rxd(mii_rxd),
    .ack_tx(ack_tx), .ack_rx(ack_rx), .tx_snap(tx_snap), .rx_snap(rx_snap),
    .tx_evt(tx_evt), .rx_evt(rx_evt), .rx_src_id(rx_src_id),
    .rx_seq_id(rx_seq_id));

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R4: wanted type per direction and role
  function automatic logic [3:0] want_of(input bit rx, input bit slave);
    if (rx) return slave ? 4'h0 : 4'h1;
    return slave ? 4'h1 : 4'h0;
  endfunction

  function automatic bit qualifies(input bit rx, input bit slave,
                                   input logic [3:0] mt, input logic [15:0] et,
                                   input int nbytes, input int err_nib);
    return (et == PTP_ET) && (mt == want_of(rx, slave)) &&
           (nbytes >= MINB) && (err_nib < 0);
  endfunction

  task automatic put_nib(input bit rx, input logic [3:0] n, input bit er);
    @(negedge clk);
    if (rx) begin mii_rx_dv = 1'b1; mii_rxd = n; mii_rx_er = er; end
    else    begin mii_tx_en = 1'b1; mii_txd = n; end
  endtask

  task automatic send(input bit rx, input logic [3:0] mt, input logic [15:0] et,
                      input int nbytes, input int err_nib,
                      input logic [47:0] src, input logic [15:0] seq);
    logic [7:0]  fr [0:127];
    logic [63:0] t_sfd;
    bit          q;
    string       tag;
    for (int b = 0; b < 128; b++) fr[b] = 8'($urandom);
    fr[12] = et[15:8];
    fr[13] = et[7:0];
    fr[14] = {fr[14][7:4], mt};
    for (int b = 0; b < 6; b++) fr[34+b] = src[47-8*b -: 8];
    fr[44] = seq[15:8];
    fr[45] = seq[7:0];
    for (int p = 0; p < 15; p++) put_nib(rx, 4'h5, 1'b0);
    @(negedge clk);
    t_sfd = now_time;
    if (rx) begin mii_rx_dv = 1'b1; mii_rxd = 4'hD; mii_rx_er = 1'b0; end
    else    begin mii_tx_en = 1'b1; mii_txd = 4'hD; end
    for (int b = 0; b < nbytes; b++) begin
      put_nib(rx, fr[b][3:0], err_nib == 2*b);
      put_nib(rx, fr[b][7:4], err_nib == 2*b + 1);
    end
    @(negedge clk);
    mii_tx_en = 1'b0; mii_rx_dv = 1'b0; mii_rx_er = 1'b0;
    q = qualifies(rx, cfg_slave, mt, et, nbytes, err_nib);
    if (err_nib >= 0)                        tag = "R9";
    else if (nbytes < MINB)                  tag = "R5";
    else if (et != PTP_ET || mt > 4'h1)      tag = "R3";
    else if (!q)                             tag = "R4";
    else if (cfg_nolock)                     tag = "R7";
    else if (m_evt[rx])                      tag = "R6";
    else                                     tag = "R2";
    if (q && (!m_evt[rx] || cfg_nolock)) begin
      m_snap[rx] = t_sfd;
      m_evt[rx]  = 1'b1;
      if (rx) begin m_src = src; m_seq = seq; end
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, rx ? rx_snap : tx_snap, m_snap[rx]);
    chk(tag, {63'd0, rx ? rx_evt : tx_evt}, {63'd0, m_evt[rx]});
    if (rx) begin
      chk("R8", {16'd0, rx_src_id}, {16'd0, m_src});
      chk("R8", {48'd0, rx_seq_id}, {48'd0, m_seq});
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic ack(input bit rx);
    @(negedge clk);
    if (rx) ack_rx = 1'b1; else ack_tx = 1'b1;
    @(negedge clk);
    ack_rx = 1'b0; ack_tx = 1'b0;
    m_evt[rx] = 1'b0;
    chk("R6", {63'd0, rx ? rx_evt : tx_evt}, 64'd0);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    logic [3:0]  mts [4];
    void'($urandom(32'd1588));
    mts[0] = 4'h0; mts[1] = 4'h1; mts[2] = 4'h8; mts[3] = 4'h9;
    m_snap[0] = '0; m_snap[1] = '0; m_evt[0] = 0; m_evt[1] = 0;
    m_src = '0; m_seq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", tx_snap, 64'd0);
    chk("R1", rx_snap, 64'd0);
    chk("R1", {62'd0, tx_evt, rx_evt}, 64'd0);
    chk("R1", {rx_src_id, rx_seq_id}, 64'd0);

    // R2 / R4: master stamps outgoing Sync
    send(0, 4'h0, PTP_ET, 64, -1, 48'h0, 16'h0);
    // R8: master stamps incoming Delay_Req with identity and sequence
    send(1, 4'h1, PTP_ET, 60, -1, 48'hA1B2_C3D4_E5F6, 16'hBEEF);
    // R6: frozen transmit snapshot
    send(0, 4'h0, PTP_ET, 64, -1, 48'h0, 16'h0);
    ack(0);
    send(0, 4'h0, PTP_ET, 50, -1, 48'h0, 16'h0);
    ack(0);
    ack(1);
    // R3: Follow_Up, Delay_Resp and foreign EtherType never commit
    send(1, 4'h8, PTP_ET, 64, -1, 48'h1111_2222_3333, 16'h0102);
    send(0, 4'h9, PTP_ET, 64, -1, 48'h0, 16'h0);
    send(1, 4'h1, 16'h0800, 64, -1, 48'h4444_5555_6666, 16'h0304);
    // R5: short frame, then exactly the minimum
    send(1, 4'h1, PTP_ET, 40, -1, 48'h7777_8888_9999, 16'h0506);
    send(1, 4'h1, PTP_ET, MINB, -1, 48'h0102_0304_0506, 16'h0708);
    ack(1);
    // R9: error on a late nibble
    send(1, 4'h1, PTP_ET, 64, 100, 48'hDEAD_BEEF_0000, 16'h0909);
    // R4: slave role
    cfg_slave = 1'b1;
    send(0, 4'h0, PTP_ET, 64, -1, 48'h0, 16'h0);
    send(0, 4'h1, PTP_ET, 64, -1, 48'h0, 16'h0);
    send(1, 4'h1, PTP_ET, 64, -1, 48'hCAFE_0000_0001, 16'h1234);
    send(1, 4'h0, PTP_ET, 64, -1, 48'hCAFE_0000_0002, 16'h1235);
    // R7: no-lock overwrite without ack
    cfg_nolock = 1'b1;
    send(1, 4'h0, PTP_ET, 64, -1, 48'hCAFE_0000_0003, 16'h1236);
    send(1, 4'h0, PTP_ET, 70, -1, 48'hCAFE_0000_0004, 16'h1237);
    send(0, 4'h1, PTP_ET, 64, -1, 48'h0, 16'h0);

    for (int n = 0; n < 60; n++) begin
      int nb, en;
      logic [15:0] et;
      if ($urandom % 6 == 0) cfg_slave = ~cfg_slave;
      if ($urandom % 5 == 0) cfg_nolock = ~cfg_nolock;
      if ($urandom % 3 == 0) ack($urandom % 2 == 1);
      nb = 40 + int'($urandom % 40);
      en = ($urandom % 8 == 0) ? int'($urandom % (2*nb)) : -1;
      et = ($urandom % 6 == 0) ? 16'h0800 : PTP_ET;
      if ($urandom % 2 == 1)
        send(1, mts[$urandom % 4], et, nb, en, {$urandom, 16'($urandom)}, 16'($urandom));
      else
        send(0, mts[$urandom % 4], et, nb, -1, 48'h0, 16'h0);
    end
    finish_up();
  end
endmodule